// File: doc/BRIEF.md
# Thread Block Dispatcher

This block places the thread blocks of one launched grid onto a small array of streaming multiprocessor (SM) slots. A launch gives the grid extent in three dimensions, the thread extent of every block in three dimensions, and the register and shared-memory budget each block needs. All blocks of a grid have the same shape. The dispatcher tracks four resources per SM: resident blocks, resident threads, registers and shared memory. A block is handed to an SM only when every one of the four limits still holds after the block is added.

Each dispatch event gives the linear block index, the chosen SM, the number of warps the block occupies, and the lane-valid mask of its tail warp. Every warp before the tail warp is fully populated. Each SM sends a completion pulse when one of its resident blocks retires. That pulse frees the block's share of the SM, and a waiting block can then be placed there on a following cycle. A grid-done flag rises once every block has been dispatched and has retired.

Top module: `block_dispatch`

## Requirements
- R1: An SM never holds more than 8 resident blocks or more than 1536 resident threads. A block is placed on an SM only if both counts stay within these limits after adding it.
- R2: A launch is rejected if the block has zero threads, the block has more than 1024 threads, any grid dimension is zero, or the register or shared-memory request of one block is larger than a whole SM's pool. On rejection `launch_err_o` is high for the single cycle after the launch, and no block is dispatched. A block of exactly 1024 threads is accepted.
- R3: The warp count reported for a block is the block's thread count divided by 32, rounded up.
- R4: Bit n of `disp_tail_mask_o` is set when lane n of the tail warp holds a thread. When the thread count is a multiple of 32, all 32 bits are set. Otherwise only bits 0 to (count mod 32) - 1 are set.
- R5: Each SM has a pool of 65536 registers and 49152 bytes of shared memory. A block is placed on an SM only while its request fits in what that SM has left. When no SM has room, dispatch stalls.
- R6: A completion pulse on an SM that holds at least one block frees one block's threads, registers and shared memory on that SM. A waiting block can then be dispatched there. A pulse on an SM that holds no block has no effect.
- R7: Blocks are issued in increasing linear index, where index = x + gx*(y + gy*z) for grid extents gx and gy. Each block goes to the lowest-numbered SM that can accept it.
- R8: At most one block is dispatched per clock. A dispatch decided in one cycle is shown on the outputs, with `disp_valid_o` high, for exactly the following cycle.
- R9: `grid_done_o` goes high in the cycle after the last outstanding completion pulse, but only once every block has been dispatched. It stays high until the next accepted launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Start a grid using the configuration inputs |
| grid_x_i | input | GDW | Grid extent in x, in blocks |
| grid_y_i | input | GDW | Grid extent in y, in blocks |
| grid_z_i | input | GDW | Grid extent in z, in blocks |
| blk_x_i | input | BDW | Block extent in x, in threads |
| blk_y_i | input | BDW | Block extent in y, in threads |
| blk_z_i | input | BDW | Block extent in z, in threads |
| reg_req_i | input | REGW | Registers needed by one block |
| smem_req_i | input | SMW | Shared-memory bytes needed by one block |
| sm_done_i | input | NUM_SM | One completion pulse per SM |
| disp_valid_o | output | 1 | A dispatch event is present |
| disp_blk_o | output | 3*GDW | Linear block index |
| disp_sm_o | output | SMIW | Destination SM |
| disp_warps_o | output | WCW | Warps occupied by the block |
| disp_tail_mask_o | output | WARP | Lane-valid mask of the tail warp |
| launch_err_o | output | 1 | Launch configuration rejected |
| grid_done_o | output | 1 | All blocks dispatched and retired |

## Verification
The bench runs one grid for each resource limit: the resident-block limit, the thread limit, the register pool and the shared-memory pool. For each grid it predicts which SM receives every block. A checker that tested a limit before adding the new block, or that left one resource out, would load a block too many onto SM 0. That would change every SM number that follows.

In the register-limited grid, dispatch has to stall until a completion arrives. Two SMs are then freed in the same cycle. The next blocks must go first to the lower SM and only then to the other one, which catches a picker that chooses by some other order, or a design that ignores completions.

Pulses sent to empty SMs must not bring grid-done forward. Launch configurations just over and exactly at the 1024-thread limit separate a correct bound from an off-by-one one. Block sizes of 33 and 30 threads exercise the partial tail mask, and a block size of 64 exercises the full one.

// File: rtl/blkdsp_pkg.sv
package blkdsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } dsp_state_e;
endpackage

// File: rtl/sm_slot.sv
// Resource ledger for one SM: resident blocks, threads, registers, shared memory.
module sm_slot #(
    parameter int MAX_BLK   = 8,
    parameter int MAX_THR   = 1536,
    parameter int REG_POOL  = 65536,
    parameter int SMEM_POOL = 49152,
    parameter int TW        = 11,
    parameter int REGW      = 17,
    parameter int SMW       = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic            done_i,
    input  logic [TW-1:0]   blk_thr_i,
    input  logic [REGW-1:0] blk_reg_i,
    input  logic [SMW-1:0]  blk_smem_i,
    output logic            fits_o,
    output logic            retire_o
);
    localparam int BW  = $clog2(MAX_BLK + 1);
    localparam int UTW = $clog2(MAX_THR + 1);
    localparam int URW = $clog2(REG_POOL + 1);
    localparam int USW = $clog2(SMEM_POOL + 1);

    typedef struct packed {
        logic [BW-1:0]  blocks;
        logic [UTW-1:0] thr;
        logic [URW-1:0] regs;
        logic [USW-1:0] smem;
    } ledger_t;

    ledger_t q, d;

    logic [BW:0]  blk_sum;
    logic [UTW:0] thr_sum;
    logic [URW:0] reg_sum;
    logic [USW:0] sm_sum;

    always_comb begin
        blk_sum = {1'b0, q.blocks} + (BW+1)'(1);
        thr_sum = {1'b0, q.thr}    + (UTW+1)'(blk_thr_i);
        reg_sum = {1'b0, q.regs}   + (URW+1)'(blk_reg_i);
        sm_sum  = {1'b0, q.smem}   + (USW+1)'(blk_smem_i);
        fits_o  = (blk_sum <= (BW+1)'(MAX_BLK))   &&
                  (thr_sum <= (UTW+1)'(MAX_THR))  &&
                  (reg_sum <= (URW+1)'(REG_POOL)) &&
                  (sm_sum  <= (USW+1)'(SMEM_POOL));
        retire_o = done_i && (q.blocks != '0);

        d = q;
        if (take_i) begin
            d.blocks = d.blocks + BW'(1);
            d.thr    = d.thr    + UTW'(blk_thr_i);
            d.regs   = d.regs   + URW'(blk_reg_i);
            d.smem   = d.smem   + USW'(blk_smem_i);
        end
        if (retire_o) begin
            d.blocks = d.blocks - BW'(1);
            d.thr    = d.thr    - UTW'(blk_thr_i);
            d.regs   = d.regs   - URW'(blk_reg_i);
            d.smem   = d.smem   - USW'(blk_smem_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_slot_caps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.blocks <= BW'(MAX_BLK)) && (q.thr <= UTW'(MAX_THR)));
    assert_slot_pools_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.regs <= URW'(REG_POOL)) && (q.smem <= USW'(SMEM_POOL)));
    assert_empty_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !take_i && q.blocks == '0) |=> (q.blocks == '0));
endmodule

// File: rtl/warp_split.sv
// Turns a block's thread count into its warp count and its tail-warp lane mask.
module warp_split #(
    parameter int WARP = 32,
    parameter int TW   = 11,
    parameter int WCW  = 6
) (
    input  logic [TW-1:0]   thr_i,
    output logic [WCW-1:0]  warps_o,
    output logic [WARP-1:0] tail_mask_o
);
    localparam int LW = $clog2(WARP);

    logic [TW:0]   rounded;
    logic [LW-1:0] rem;

    always_comb begin
        rounded = {1'b0, thr_i} + (TW+1)'(WARP - 1);
        warps_o = WCW'(rounded >> LW);
        rem     = thr_i[LW-1:0];
    end

    for (genvar l = 0; l < WARP; l++) begin : g_lane
        assign tail_mask_o[l] = (rem == '0) || (LW'(l) < rem);
    end
endmodule

// File: rtl/lowest_pick.sv
// Fixed priority: lowest-numbered requester wins.
module lowest_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
                idx_o    = IW'(i);
            end
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/block_dispatch.sv
module block_dispatch
    import blkdsp_pkg::*;
#(
    parameter int NUM_SM      = 4,
    parameter int MAX_BLK     = 8,
    parameter int MAX_THR     = 1536,
    parameter int MAX_BLK_THR = 1024,
    parameter int WARP        = 32,
    parameter int REG_POOL    = 65536,
    parameter int SMEM_POOL   = 49152,
    parameter int GDW         = 4,
    parameter int BDW         = 11,
    parameter int REGW        = $clog2(REG_POOL + 1),
    parameter int SMW         = $clog2(SMEM_POOL + 1),
    parameter int SMIW        = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
    parameter int WCW         = $clog2(MAX_BLK_THR / WARP + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch_i,
    input  logic [GDW-1:0]      grid_x_i,
    input  logic [GDW-1:0]      grid_y_i,
    input  logic [GDW-1:0]      grid_z_i,
    input  logic [BDW-1:0]      blk_x_i,
    input  logic [BDW-1:0]      blk_y_i,
    input  logic [BDW-1:0]      blk_z_i,
    input  logic [REGW-1:0]     reg_req_i,
    input  logic [SMW-1:0]      smem_req_i,
    input  logic [NUM_SM-1:0]   sm_done_i,
    output logic                disp_valid_o,
    output logic [3*GDW-1:0]    disp_blk_o,
    output logic [SMIW-1:0]     disp_sm_o,
    output logic [WCW-1:0]      disp_warps_o,
    output logic [WARP-1:0]     disp_tail_mask_o,
    output logic                launch_err_o,
    output logic                grid_done_o
);
    localparam int BIW = 3 * GDW;
    localparam int TW  = $clog2(MAX_BLK_THR + 1);
    localparam int PW  = 3 * BDW;
    localparam int CW  = $clog2(NUM_SM + 1);

    typedef struct packed {
        dsp_state_e      state;
        logic [TW-1:0]   bthr;
        logic [REGW-1:0] breg;
        logic [SMW-1:0]  bsmem;
        logic [BIW-1:0]  total;
        logic [BIW-1:0]  nxt;
        logic [BIW-1:0]  comp;
        logic            disp_valid;
        logic [BIW-1:0]  disp_blk;
        logic [SMIW-1:0] disp_sm;
        logic [WCW-1:0]  warps;
        logic [WARP-1:0] mask;
        logic            err;
        logic            grid_done;
    } ctl_t;

    ctl_t q, d;

    logic [NUM_SM-1:0] fits, retire, take;
    logic [NUM_SM-1:0] gnt;
    logic [SMIW-1:0]   gidx;
    logic              gany;
    logic [WCW-1:0]    ws_warps;
    logic [WARP-1:0]   ws_mask;
    logic [PW-1:0]     thr_prod;
    logic [BIW-1:0]    grid_prod;
    logic              cfg_bad;
    logic [CW-1:0]     n_retire;

    for (genvar s = 0; s < NUM_SM; s++) begin : g_sm
        sm_slot #(
            .MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR), .REG_POOL(REG_POOL),
            .SMEM_POOL(SMEM_POOL), .TW(TW), .REGW(REGW), .SMW(SMW)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .take_i(take[s]), .done_i(sm_done_i[s]),
            .blk_thr_i(q.bthr), .blk_reg_i(q.breg), .blk_smem_i(q.bsmem),
            .fits_o(fits[s]), .retire_o(retire[s])
        );
    end

    lowest_pick #(.N(NUM_SM), .IW(SMIW)) u_pick (
        .req_i(fits), .gnt_o(gnt), .idx_o(gidx), .any_o(gany)
    );

    warp_split #(.WARP(WARP), .TW(TW), .WCW(WCW)) u_split (
        .thr_i(q.bthr), .warps_o(ws_warps), .tail_mask_o(ws_mask)
    );

    always_comb begin
        thr_prod  = PW'(blk_x_i) * PW'(blk_y_i) * PW'(blk_z_i);
        grid_prod = BIW'(grid_x_i) * BIW'(grid_y_i) * BIW'(grid_z_i);
        cfg_bad   = (thr_prod == '0) || (thr_prod > PW'(MAX_BLK_THR)) ||
                    (grid_x_i == '0) || (grid_y_i == '0) || (grid_z_i == '0) ||
                    (reg_req_i > REGW'(REG_POOL)) || (smem_req_i > SMW'(SMEM_POOL));
        n_retire = '0;
        for (int s = 0; s < NUM_SM; s++) n_retire = n_retire + CW'(retire[s]);
    end

    always_comb begin
        d            = q;
        d.disp_valid = 1'b0;
        d.err        = 1'b0;
        take         = '0;
        d.comp       = q.comp + BIW'(n_retire);
        case (q.state)
            ST_RUN: begin
                if ((q.nxt < q.total) && gany) begin
                    take         = gnt;
                    d.disp_valid = 1'b1;
                    d.disp_blk   = q.nxt;
                    d.disp_sm    = gidx;
                    d.warps      = ws_warps;
                    d.mask       = ws_mask;
                    d.nxt        = q.nxt + BIW'(1);
                end
                if ((d.nxt == q.total) && (d.comp == q.total)) d.state = ST_DONE;
            end
            default: begin
                if (launch_i) begin
                    if (cfg_bad) begin
                        d.err = 1'b1;
                    end else begin
                        d.state = ST_RUN;
                        d.bthr  = TW'(thr_prod);
                        d.breg  = reg_req_i;
                        d.bsmem = smem_req_i;
                        d.total = grid_prod;
                        d.nxt   = '0;
                        d.comp  = '0;
                    end
                end
            end
        endcase
        d.grid_done = (d.state == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign disp_valid_o     = q.disp_valid;
    assign disp_blk_o       = q.disp_blk;
    assign disp_sm_o        = q.disp_sm;
    assign disp_warps_o     = q.warps;
    assign disp_tail_mask_o = q.mask;
    assign launch_err_o     = q.err;
    assign grid_done_o      = q.grid_done;

    assert_single_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));
    assert_index_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |-> (disp_blk_o < q.total));
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grid_done_o |-> !disp_valid_o);
    assert_tail_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |-> disp_tail_mask_o[0]);
    assert_warps_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |-> (disp_warps_o != '0));
    assert_err_no_disp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch_err_o |-> !disp_valid_o);
endmodule

// File: tb/sim_block_dispatch.sv
module sim_block_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NSM  = 4;
    localparam int GDW  = 4;
    localparam int BDW  = 11;
    localparam int REGW = 17;
    localparam int SMW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch = 1'b0;
    logic [GDW-1:0] gx = '0, gy = '0, gz = '0;
    logic [BDW-1:0] bx = '0, by = '0, bz = '0;
    logic [REGW-1:0] rreq = '0;
    logic [SMW-1:0]  sreq = '0;
    logic [NSM-1:0]  done = '0;
    logic dv, err, gdone;
    logic [3*GDW-1:0] blk;
    logic [1:0] sm;
    logic [5:0] warps;
    logic [31:0] tmask;

    always #(CLK_PERIOD/2) clk = ~clk;

    block_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .launch_i(launch),
        .grid_x_i(gx), .grid_y_i(gy), .grid_z_i(gz),
        .blk_x_i(bx), .blk_y_i(by), .blk_z_i(bz),
        .reg_req_i(rreq), .smem_req_i(sreq), .sm_done_i(done),
        .disp_valid_o(dv), .disp_blk_o(blk), .disp_sm_o(sm),
        .disp_warps_o(warps), .disp_tail_mask_o(tmask),
        .launch_err_o(err), .grid_done_o(gdone)
    );

    typedef struct packed {
        logic [11:0] idx;
        logic [1:0]  sm;
        logic [5:0]  warps;
        logic [31:0] mask;
    } ev_t;

    ev_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int disp_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: compares each dispatch event with the scoreboard (R3 R4 R7 R8).
    always @(negedge clk) begin
        if (rst_n && dv) begin
            ev_t got, want;
            got = '{idx: blk, sm: sm, warps: warps, mask: tmask};
            disp_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected dispatch", longint'(got), 0);
            end else begin
                want = exp_q.pop_front();
                chk(got == want, "R7/R3/R4 dispatch event", longint'(got), longint'(want));
            end
        end
    end

    task automatic push(input int idx, input int s, input int w, input logic [31:0] m);
        exp_q.push_back('{idx: 12'(idx), sm: 2'(s), warps: 6'(w), mask: m});
    endtask

    task automatic do_launch(input int x, input int y, input int z,
                             input int a, input int b, input int c,
                             input int r, input int m);
        @(negedge clk);
        gx = GDW'(x); gy = GDW'(y); gz = GDW'(z);
        bx = BDW'(a); by = BDW'(b); bz = BDW'(c);
        rreq = REGW'(r); sreq = SMW'(m);
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
    endtask

    task automatic pulse(input logic [NSM-1:0] m);
        @(negedge clk);
        done = m;
        @(negedge clk);
        done = '0;
    endtask

    task automatic wait_disp(input int n);
        while (disp_cnt < n) @(negedge clk);
    endtask

    task automatic free_all(input int s, input int n);
        for (int i = 0; i < n; i++) pulse(NSM'(1) << s);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk(!dv && !gdone && !err, "reset outputs quiet", {dv, gdone, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dv && !gdone, "reset idle after release", {dv, gdone}, 0);

        // R2: 32x32x2 = 2048 threads rejected
        do_launch(2, 1, 1, 32, 32, 2, 0, 0);
        chk(err == 1'b1, "R2 oversize block err", err, 1);
        @(negedge clk);
        chk(err == 1'b0, "R2 err one cycle", err, 0);
        // R2: zero grid dimension
        do_launch(0, 1, 1, 4, 1, 1, 0, 0);
        chk(err == 1'b1, "R2 zero grid err", err, 1);
        // R2: shared memory larger than one SM pool
        do_launch(1, 1, 1, 4, 1, 1, 0, 60000);
        chk(err == 1'b1, "R2 smem pool err", err, 1);
        repeat (4) @(negedge clk);
        chk(disp_cnt == 0 && !gdone, "R2 rejected launch dispatches nothing", disp_cnt, 0);

        // R2 boundary: exactly 1024 threads accepted; R3 32 warps, R4 full mask
        push(0, 0, 32, 32'hFFFF_FFFF);
        do_launch(1, 1, 1, 32, 32, 1, 0, 0);
        chk(err == 1'b0, "R2 1024-thread block accepted", err, 0);
        wait_disp(1);
        free_all(0, 1);
        chk(gdone == 1'b1, "R9 done after single block", gdone, 1);
        repeat (3) @(negedge clk);
        chk(gdone == 1'b1, "R9 done held", gdone, 1);

        // Grid A: 4 blocks of 256 threads on SM0; R6 pulses on empty SM ignored
        base = disp_cnt;
        for (int i = 0; i < 4; i++) push(i, 0, 8, 32'hFFFF_FFFF);
        do_launch(4, 1, 1, 16, 16, 1, 8192, 0);
        chk(gdone == 1'b0, "R9 done cleared by launch", gdone, 0);
        wait_disp(base + 4);
        free_all(1, 4);
        chk(gdone == 1'b0, "R6 pulses on empty SM ignored", gdone, 0);
        free_all(0, 3);
        chk(gdone == 1'b0, "R9 done waits for last completion", gdone, 0);
        free_all(0, 1);
        chk(gdone == 1'b1, "R9 done after last completion", gdone, 1);

        // Grid B: 12 blocks of 33 threads, resident block cap R1; R4 mask 0x1
        base = disp_cnt;
        for (int i = 0; i < 12; i++) push(i, (i < 8) ? 0 : 1, 2, 32'h0000_0001);
        do_launch(12, 1, 1, 3, 11, 1, 0, 0);
        wait_disp(base + 12);
        free_all(0, 8);
        free_all(1, 4);
        chk(gdone == 1'b1, "R1 block-cap grid completes", gdone, 1);

        // Grid C: 5 blocks of 512 threads, thread cap R1 (3 per SM), z-extent indexing R7
        base = disp_cnt;
        for (int i = 0; i < 5; i++) push(i, (i < 3) ? 0 : 1, 16, 32'hFFFF_FFFF);
        do_launch(1, 1, 5, 16, 32, 1, 0, 0);
        wait_disp(base + 5);
        free_all(0, 3);
        free_all(1, 2);
        chk(gdone == 1'b1, "R1 thread-cap grid completes", gdone, 1);

        // Grid D: 6 blocks, 30 threads, 20000 B shared memory: 2 per SM R5; R4 mask
        base = disp_cnt;
        for (int i = 0; i < 6; i++) push(i, i / 2, 1, 32'h3FFF_FFFF);
        do_launch(3, 2, 1, 10, 3, 1, 0, 20000);
        wait_disp(base + 6);
        for (int s = 0; s < 3; s++) free_all(s, 2);
        chk(gdone == 1'b1, "R5 smem grid completes", gdone, 1);

        // Grid E: 16 blocks, 20000 registers: 3 per SM, then stall (R5), refill (R6)
        base = disp_cnt;
        for (int i = 0; i < 12; i++) push(i, i / 3, 2, 32'hFFFF_FFFF);
        do_launch(4, 4, 1, 8, 8, 1, 20000, 0);
        wait_disp(base + 12);
        repeat (8) @(negedge clk);
        chk(disp_cnt == base + 12, "R5 stall when register pools exhausted", disp_cnt - base, 12);
        push(12, 2, 2, 32'hFFFF_FFFF);
        pulse(4'b0100);
        wait_disp(base + 13);
        chk(1'b1, "R6 refill after completion", 0, 0);
        push(13, 0, 2, 32'hFFFF_FFFF);
        push(14, 3, 2, 32'hFFFF_FFFF);
        pulse(4'b1001);
        wait_disp(base + 15);
        repeat (4) @(negedge clk);
        chk(disp_cnt == base + 15, "R8 one block per freed slot", disp_cnt - base, 15);
        push(15, 1, 2, 32'hFFFF_FFFF);
        pulse(4'b0010);
        wait_disp(base + 16);
        for (int k = 0; k < 2; k++) pulse(4'b1111);
        chk(gdone == 1'b0, "R9 not done with blocks resident", gdone, 0);
        pulse(4'b1111);
        chk(gdone == 1'b1, "R9 register grid completes", gdone, 1);

        chk(exp_q.size() == 0, "R7 all expected dispatches seen", exp_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", disp_cnt, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule